// File: doc/BRIEF.md
# Extended Integer Divide Unit

This block is the multi-cycle division engine of a 16-bit microcontroller datapath. It takes three register values from the register file: an accumulator D, an index X and an index Y. It runs one of three divide operations on them: signed 16/16, unsigned 32/16 or signed 32/16. When it finishes it returns a quotient and a remainder, a mask that tells the register file which of D, X and Y to write, and the four condition flags carry, zero, negative and overflow.

A caller applies the operands and a two-bit operation code together with a one-cycle `start_i`. The unit samples everything on that edge. It then iterates on operand magnitudes with a restoring shift-subtract core and corrects the signs afterwards. The result appears together with a one-cycle `done_o` after a latency that is the same for every operation. The quotient truncates toward zero and the remainder takes the sign of the dividend. A zero divisor is reported through the carry flag alone.

Top module: `xdiv_unit`

## Requirements
- R1: Operation code 2'b00 is signed 16/16. It divides D by X, both two's complement. The quotient goes to X and the remainder to D, and the write mask on `done_o` is 3'b011 (bit 0 = D, bit 1 = X, bit 2 = Y). The quotient truncates toward zero and a nonzero remainder has the sign of D.
- R2: Operation code 2'b01 is unsigned 32/16. The dividend is {Y,D}, with Y as the upper half, and the divisor is X. The quotient goes to Y and the remainder to D, and the write mask is 3'b101.
- R3: Operation code 2'b10 is signed 32/16. It uses the same register pairing and write mask as R2, with {Y,D} and X read as two's complement. Truncation and remainder sign follow R1.
- R4: With a zero divisor the unit raises C, the write mask on `done_o` is 3'b000, and Z, N and V keep the values they had before the operation.
- R5: With a nonzero divisor C is cleared, Z is set exactly when the full quotient is zero, and N equals bit 15 of the quotient that is written.
- R6: In unsigned 32/16, V is set when the quotient exceeds 16'hFFFF. The low 16 quotient bits are still written.
- R7: In both signed operations, V is set when the quotient lies outside -32768..32767. The low 16 bits are still written, so -32768 / -1 writes 16'h8000 with V = 1.
- R8: An accepted start makes `busy_o` high from the next cycle. `done_o` is a single-cycle pulse that becomes visible exactly 2*DW/STEPS+1 clock edges after the accepting edge, which is 33 at the defaults. `busy_o` is low in the `done_o` cycle.
- R9: A start while `busy_o` is high is ignored and does not disturb the operation in flight. A start with operation code 2'b11 is ignored: no busy and no done.
- R10: After reset `busy_o`, `done_o`, the write mask, the four flags and the three result outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, sampled together with the operands |
| op_i | input | 2 | Operation code: 00 signed 16/16, 01 unsigned 32/16, 10 signed 32/16, 11 none |
| d_i | input | DW | D register value |
| x_i | input | DW | X register value |
| y_i | input | DW | Y register value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wr_en_o | output | 3 | Register write mask valid with done_o: bit 0 D, bit 1 X, bit 2 Y |
| d_o | output | DW | Remainder value for D |
| x_o | output | DW | Quotient value for X (signed 16/16) |
| y_o | output | DW | Quotient value for Y (32/16 operations) |
| c_o | output | 1 | Carry flag: divide by zero |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |

## Verification
The embedded properties watch the control behaviour on every cycle. They check that done is a single pulse at the fixed latency, that busy follows an accepted start, that a reserved code or a busy start is ignored, that the mask only appears with done, that a zero divisor writes nothing and leaves Z, N and V alone, and that the partial remainder stays below the divisor in the core. Whether quotient, remainder and flags are arithmetically right can only be shown by the bench scenarios. The bench compares each result with a behavioural model on random operands and on the corners: -32768 / -1, the all-ones 32-bit dividend, the most negative 32-bit dividend and zero divisors that follow results with different flags.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;
  typedef enum logic [1:0] {
    OP_SDIV16 = 2'b00,
    OP_UDIV32 = 2'b01,
    OP_SDIV32 = 2'b10,
    OP_NONE   = 2'b11
  } xdiv_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } xdiv_st_e;

  localparam logic [2:0] WR_D = 3'b001;
  localparam logic [2:0] WR_X = 3'b010;
  localparam logic [2:0] WR_Y = 3'b100;
endpackage

// File: rtl/xdiv_prep.sv
// Operand conditioning: builds dividend/divisor magnitudes and sign info.
module xdiv_prep
  import xdiv_pkg::*;
#(
  parameter int DW = 16
) (
  input  xdiv_op_e         op_i,
  input  logic [DW-1:0]    d_i,
  input  logic [DW-1:0]    x_i,
  input  logic [DW-1:0]    y_i,
  output logic [2*DW-1:0]  dvd_mag_o,
  output logic [DW-1:0]    dvs_mag_o,
  output logic             q_neg_o,
  output logic             r_neg_o,
  output logic             dvs_zero_o,
  output logic             op_valid_o
);
  localparam int QW = 2 * DW;

  logic [QW-1:0] dvd_raw;
  logic          dvd_sgn;
  logic          dvs_sgn;
  logic          is_signed;

  always_comb begin
    dvd_raw   = {y_i, d_i};
    dvd_sgn   = 1'b0;
    is_signed = 1'b0;
    unique case (op_i)
      OP_SDIV16: begin
        dvd_raw   = {{DW{d_i[DW-1]}}, d_i};
        dvd_sgn   = d_i[DW-1];
        is_signed = 1'b1;
      end
      OP_SDIV32: begin
        dvd_sgn   = y_i[DW-1];
        is_signed = 1'b1;
      end
      default: begin
        dvd_sgn   = 1'b0;
        is_signed = 1'b0;
      end
    endcase
    dvs_sgn    = is_signed & x_i[DW-1];
    dvd_mag_o  = dvd_sgn ? (~dvd_raw + 1'b1) : dvd_raw;
    dvs_mag_o  = dvs_sgn ? (~x_i + 1'b1) : x_i;
    q_neg_o    = dvd_sgn ^ dvs_sgn;
    r_neg_o    = dvd_sgn;
    dvs_zero_o = (x_i == '0);
    op_valid_o = (op_i != OP_NONE);
  end
endmodule

// File: rtl/xdiv_core.sv
// Restoring shift-subtract core on magnitudes, STEPS quotient bits per cycle.
module xdiv_core #(
  parameter int DW    = 16,
  parameter int STEPS = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [2*DW-1:0] dvd_i,
  input  logic [DW-1:0]   dvs_i,
  output logic [2*DW-1:0] quo_o,
  output logic [DW-1:0]   rem_o
);
  localparam int QW = 2 * DW;

  logic [QW-1:0] quo_q, quo_d;
  logic [DW-1:0] rem_q, rem_d;
  logic [DW-1:0] dvs_q, dvs_d;

  logic [QW-1:0] q_ch [STEPS+1];
  logic [DW-1:0] r_ch [STEPS+1];

  assign q_ch[0] = quo_q;
  assign r_ch[0] = rem_q;

  for (genvar g = 0; g < STEPS; g++) begin : g_stage
    logic [DW:0] sh;
    logic        ge;
    assign sh          = {r_ch[g], q_ch[g][QW-1]};
    assign ge          = (sh >= {1'b0, dvs_q});
    assign r_ch[g+1]   = ge ? (sh[DW-1:0] - dvs_q) : sh[DW-1:0];
    assign q_ch[g+1]   = {q_ch[g][QW-2:0], ge};
  end

  always_comb begin
    quo_d = quo_q;
    rem_d = rem_q;
    dvs_d = dvs_q;
    if (load_i) begin
      quo_d = dvd_i;
      rem_d = '0;
      dvs_d = dvs_i;
    end else if (step_i) begin
      quo_d = q_ch[STEPS];
      rem_d = r_ch[STEPS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
    end else if (load_i || step_i) begin
      quo_q <= quo_d;
      rem_q <= rem_d;
      dvs_q <= dvs_d;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  // R1: partial remainder always below the divisor while iterating
  assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/xdiv_fix.sv
// Sign fix-up, overflow detection and flag derivation.
module xdiv_fix
  import xdiv_pkg::*;
#(
  parameter int DW = 16
) (
  input  xdiv_op_e        op_i,
  input  logic            q_neg_i,
  input  logic            r_neg_i,
  input  logic [2*DW-1:0] quo_mag_i,
  input  logic [DW-1:0]   rem_mag_i,
  output logic [DW-1:0]   quo_o,
  output logic [DW-1:0]   rem_o,
  output logic            z_o,
  output logic            n_o,
  output logic            v_o
);
  localparam int QW = 2 * DW;

  logic [QW:0]    q_ext;
  logic [QW:0]    q_sgn;
  logic [QW-DW+1:0] q_top;

  always_comb begin
    q_ext = {1'b0, quo_mag_i};
    q_sgn = q_neg_i ? (~q_ext + 1'b1) : q_ext;
    q_top = q_sgn[QW:DW-1];
    rem_o = r_neg_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
    if (op_i == OP_UDIV32) begin
      quo_o = quo_mag_i[DW-1:0];
      v_o   = |quo_mag_i[QW-1:DW];
    end else begin
      quo_o = q_sgn[DW-1:0];
      v_o   = !((&q_top) || !(|q_top));
    end
    z_o = (quo_mag_i == '0);
    n_o = quo_o[DW-1];
  end
endmodule

// File: rtl/xdiv_unit.sv
module xdiv_unit
  import xdiv_pkg::*;
#(
  parameter int DW    = 16,
  parameter int STEPS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] d_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    wr_en_o,
  output logic [DW-1:0] d_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o,
  output logic          c_o,
  output logic          z_o,
  output logic          n_o,
  output logic          v_o
);
  localparam int QW   = 2 * DW;
  localparam int ITER = QW / STEPS;
  localparam int CW   = $clog2(ITER + 1);
  localparam int LAT  = ITER + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  // operand conditioning
  xdiv_op_e       op_in;
  logic [QW-1:0]  dvd_mag;
  logic [DW-1:0]  dvs_mag;
  logic           q_neg_in, r_neg_in, zero_in, op_valid;

  assign op_in = xdiv_op_e'(op_i);

  xdiv_prep #(.DW(DW)) u_prep (
    .op_i       (op_in),
    .d_i        (d_i),
    .x_i        (x_i),
    .y_i        (y_i),
    .dvd_mag_o  (dvd_mag),
    .dvs_mag_o  (dvs_mag),
    .q_neg_o    (q_neg_in),
    .r_neg_o    (r_neg_in),
    .dvs_zero_o (zero_in),
    .op_valid_o (op_valid)
  );

  // control state
  xdiv_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  xdiv_op_e      op_q, op_d;
  logic          q_neg_q, q_neg_d, r_neg_q, r_neg_d, zero_q, zero_d;
  logic          accept, stepping, ctl_en;

  assign accept   = start_i && (st_q == ST_IDLE) && op_valid;
  assign stepping = (st_q == ST_RUN);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    q_neg_d = q_neg_q;
    r_neg_d = r_neg_q;
    zero_d  = zero_q;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_d    = ST_RUN;
        cnt_d   = CW'(ITER);
        op_d    = op_in;
        q_neg_d = q_neg_in;
        r_neg_d = r_neg_in;
        zero_d  = zero_in;
      end
      ST_RUN: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) st_d = ST_FIN;
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign ctl_en = (st_q != ST_IDLE) || accept;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_SDIV16;
      q_neg_q <= 1'b0;
      r_neg_q <= 1'b0;
      zero_q  <= 1'b0;
    end else if (ctl_en) begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      q_neg_q <= q_neg_d;
      r_neg_q <= r_neg_d;
      zero_q  <= zero_d;
    end
  end

  // iterative core
  logic [QW-1:0] quo_mag;
  logic [DW-1:0] rem_mag;

  xdiv_core #(.DW(DW), .STEPS(STEPS)) u_core (
    .clk    (clk),
    .rst_n  (rst_ni),
    .load_i (accept),
    .step_i (stepping),
    .dvd_i  (dvd_mag),
    .dvs_i  (dvs_mag),
    .quo_o  (quo_mag),
    .rem_o  (rem_mag)
  );

  // sign fix-up and flags
  logic [DW-1:0] quo_fx, rem_fx;
  logic          z_fx, n_fx, v_fx;

  xdiv_fix #(.DW(DW)) u_fix (
    .op_i      (op_q),
    .q_neg_i   (q_neg_q),
    .r_neg_i   (r_neg_q),
    .quo_mag_i (quo_mag),
    .rem_mag_i (rem_mag),
    .quo_o     (quo_fx),
    .rem_o     (rem_fx),
    .z_o       (z_fx),
    .n_o       (n_fx),
    .v_o       (v_fx)
  );

  // result registers
  logic          fin;
  logic          res_en, xq_en, yq_en;
  logic [2:0]    wr_d;
  logic          done_d;

  assign fin    = (st_q == ST_FIN);
  assign res_en = fin && !zero_q;
  assign xq_en  = res_en && (op_q == OP_SDIV16);
  assign yq_en  = res_en && (op_q != OP_SDIV16);

  always_comb begin
    done_d = fin;
    wr_d   = 3'b000;
    if (res_en) wr_d = (op_q == OP_SDIV16) ? (WR_D | WR_X) : (WR_D | WR_Y);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      wr_en_o <= 3'b000;
    end else begin
      done_o  <= done_d;
      wr_en_o <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      d_o <= '0;
      z_o <= 1'b0;
      n_o <= 1'b0;
      v_o <= 1'b0;
    end else if (res_en) begin
      d_o <= rem_fx;
      z_o <= z_fx;
      n_o <= n_fx;
      v_o <= v_fx;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    x_o <= '0;
    else if (xq_en) x_o <= quo_fx;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    y_o <= '0;
    else if (yq_en) y_o <= quo_fx;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  c_o <= 1'b0;
    else if (fin) c_o <= zero_q;
  end

  assign busy_o = (st_q != ST_IDLE);

  // latency watch counter for the checks below
  logic [CW:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     lat_cnt <= '0;
    else if (accept) lat_cnt <= '0;
    else if (busy_o) lat_cnt <= lat_cnt + 1'b1;
  end

  assert_fixed_latency_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |-> (lat_cnt == (CW+1)'(LAT)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (start_i && !busy_o && op_i != 2'b11) |=> busy_o);

  assert_reserved_ignored_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (start_i && !busy_o && op_i == 2'b11) |=> !busy_o);

  assert_mask_only_on_done_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_o != 3'b000) |-> done_o);

  assert_zero_div_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_o && c_o) |-> (wr_en_o == 3'b000 && $stable(z_o) && $stable(n_o) && $stable(v_o)));
endmodule

// File: tb/test_xdiv_unit.sv
module test_xdiv_unit;
  localparam int DW  = 16;
  localparam int LAT = 2 * DW + 1;

  typedef struct {
    logic [2:0]  mask;
    logic        c, z, n, v;
    logic [15:0] q, r;
    int          due;
    string       req;
  } exp_t;

  logic        clk, rst_n, start;
  logic [1:0]  op;
  logic [15:0] d_in, x_in, y_in;
  logic        busy, done, c_f, z_f, n_f, v_f;
  logic [2:0]  wr_en;
  logic [15:0] d_out, x_out, y_out;

  int checks = 0, failures = 0, cyc = 0;
  exp_t sb[$];
  logic mz = 0, mn = 0, mv = 0;

  xdiv_unit #(.DW(DW), .STEPS(1)) i_xdiv_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
    .d_i(d_in), .x_i(x_in), .y_i(y_in),
    .busy_o(busy), .done_o(done), .wr_en_o(wr_en),
    .d_o(d_out), .x_o(x_out), .y_o(y_out),
    .c_o(c_f), .z_o(z_f), .n_o(n_f), .v_o(v_f));

  initial clk = 0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic fin_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    fin_run();
  end

  function automatic exp_t model(logic [1:0] o, logic [15:0] d, logic [15:0] x,
                                 logic [15:0] y, string req);
    exp_t e;
    longint a, b, q, r;
    e.req = req;
    if (o == 2'b01) begin
      a = longint'({32'd0, y, d});
      b = longint'({48'd0, x});
    end else begin
      b = longint'($signed(x));
      if (o == 2'b00) a = longint'($signed(d));
      else            a = longint'($signed({y, d}));
    end
    if (b == 0) begin
      e.c = 1; e.mask = 3'b000; e.z = mz; e.n = mn; e.v = mv; e.q = 0; e.r = 0;
    end else begin
      q = a / b; r = a % b;
      e.c = 0;
      e.q = q[15:0]; e.r = r[15:0];
      e.z = (q == 0); e.n = e.q[15];
      e.v = (o == 2'b01) ? (q > 65535) : (q > 32767 || q < -32768);
      e.mask = (o == 2'b00) ? 3'b011 : 3'b101;
    end
    mz = e.z; mn = e.n; mv = e.v;
    return e;
  endfunction

  task automatic run_op(logic [1:0] o, logic [15:0] d, logic [15:0] x,
                        logic [15:0] y, string req);
    exp_t e;
    @(negedge clk);
    e = model(o, d, x, y, req);
    e.due = cyc + 1 + LAT;
    sb.push_back(e);
    op = o; d_in = d; x_in = x; y_in = y; start = 1;
    @(negedge clk);
    start = 0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (sb.size() == 0) begin
          checks++; failures++;
          $display("FAIL R9 unexpected done act=1 exp=0");
        end else begin
          exp_t e;
          logic [15:0] qa;
          e = sb.pop_front();
          qa = (e.mask == 3'b011) ? x_out : y_out;
          checks++;
          if (cyc != e.due) begin
            failures++;
            $display("FAIL R8 latency act=%0d exp=%0d", cyc, e.due);
          end
          checks++;
          if ({wr_en, c_f, z_f, n_f, v_f} != {e.mask, e.c, e.z, e.n, e.v} ||
              (e.mask != 0 && (qa != e.q || d_out != e.r))) begin
            failures++;
            $display("FAIL %s act mask=%b cznv=%b%b%b%b q=%h r=%h exp mask=%b cznv=%b%b%b%b q=%h r=%h",
                     e.req, wr_en, c_f, z_f, n_f, v_f, qa, d_out,
                     e.mask, e.c, e.z, e.n, e.v, e.q, e.r);
          end
        end
      end else if (wr_en != 0) begin
        checks++; failures++;
        $display("FAIL R1 mask without done act=%b exp=000", wr_en);
      end
    end
  end

  initial begin
    start = 0; op = 0; d_in = 0; x_in = 0; y_in = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    checks++;
    if ({busy, done, wr_en, c_f, z_f, n_f, v_f, d_out, x_out, y_out} != '0) begin
      failures++;
      $display("FAIL R10 reset state act=%h exp=0",
               {busy, done, wr_en, c_f, z_f, n_f, v_f, d_out, x_out, y_out});
    end

    // R1 signed 16/16 patterns
    run_op(2'b00, 16'd100, 16'd7, 16'h0, "R1");
    run_op(2'b00, -16'sd100, 16'd7, 16'h0, "R1");
    run_op(2'b00, 16'd100, -16'sd7, 16'h0, "R1");
    run_op(2'b00, 16'd5, 16'd9, 16'h0, "R5");
    // R7 most negative / -1
    run_op(2'b00, 16'h8000, 16'hFFFF, 16'h0, "R7");
    // R4 zero divisor after V/N set: flags must hold
    run_op(2'b00, 16'h1234, 16'h0000, 16'h5, "R4");
    // R2 unsigned 32/16
    run_op(2'b01, 16'h5678, 16'h1000, 16'h0012, "R2");
    run_op(2'b01, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R6");
    run_op(2'b01, 16'hFFFF, 16'h0001, 16'h0000, "R6");
    run_op(2'b01, 16'h0003, 16'h0004, 16'h0000, "R5");
    run_op(2'b01, 16'h0003, 16'h0000, 16'h0000, "R4");
    // R3 signed 32/16
    run_op(2'b10, 16'h0000, 16'hFFFE, 16'hFFFF, "R3");
    run_op(2'b10, 16'h0001, 16'h0003, 16'h8000, "R7");
    run_op(2'b10, 16'h0000, 16'hFFFF, 16'h8000, "R7");
    run_op(2'b10, 16'hFFF1, 16'h0004, 16'hFFFF, "R3");
    run_op(2'b10, 16'h0000, 16'h0000, 16'h8000, "R4");

    // R9 start while busy ignored
    @(negedge clk);
    begin
      exp_t e;
      e = model(2'b00, 16'd1000, 16'd10, 16'd0, "R9");
      e.due = cyc + 1 + LAT;
      sb.push_back(e);
      op = 2'b00; d_in = 16'd1000; x_in = 16'd10; y_in = 0; start = 1;
      @(negedge clk); start = 0;
      repeat (5) @(negedge clk);
      op = 2'b01; d_in = 16'hAAAA; x_in = 16'd3; y_in = 16'h7; start = 1;
      @(negedge clk); start = 0;
      while (sb.size() != 0) @(negedge clk);
    end
    // R9 reserved op ignored
    @(negedge clk);
    op = 2'b11; d_in = 16'd9; x_in = 16'd3; start = 1;
    @(negedge clk); start = 0;
    checks++;
    if (busy !== 1'b0) begin
      failures++;
      $display("FAIL R9 reserved op busy act=%b exp=0", busy);
    end
    repeat (LAT + 4) @(negedge clk);

    // random mix
    for (int i = 0; i < 80; i++) begin
      logic [1:0]  o;
      logic [15:0] dd, xx, yy;
      o  = 2'($urandom_range(0, 2));
      dd = 16'($urandom);
      yy = 16'($urandom);
      case ($urandom_range(0, 3))
        0: xx = 16'($urandom_range(1, 20));
        1: xx = 16'($urandom);
        2: xx = 16'h0000;
        default: xx = -16'($urandom_range(1, 300));
      endcase
      if (o == 2'b01 && i[0]) yy = 16'($urandom_range(0, 30));
      run_op(o, dd, xx, yy, o == 2'b00 ? "R1" : (o == 2'b01 ? "R2" : "R3"));
    end

    repeat (5) @(negedge clk);
    fin_run();
  end
endmodule